// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block tracks exceptions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and turns them into a clean, program-ordered trap. Each stage reports its own fault strobe. The strobe is not acted on where it is raised. Instead, the fault is folded into a small record of valid bit, fault flag, cause code and PC. That record travels with the instruction through the decode, execute and memory tracking registers. The only place a trap can happen is the commit point, where the instruction sits in the memory stage and the pipeline advances.

At that point the controller resolves any synchronous fault carried by the memory-stage instruction, or else a pending interrupt. When it commits, it does four things in the same cycle: it latches the cause and exception PC, asserts the kill signals for fetch, decode and execute, and suppresses the writeback of the trapping instruction. Next, a small state machine with two states, ST_RUN and ST_TRAP, drives a redirect to a fixed handler vector for one advance cycle.

The transition ST_RUN to ST_TRAP is taken on a commit. ST_RUN holds otherwise. ST_TRAP returns to ST_RUN on the first cycle with the advance enable high, and holds while the advance enable is low.

Top module: `precise_trap_ctrl`

## Requirements
- R1: After reset, cause_o and epc_o are 0, all kill, suppress and redirect outputs are low, and no tracked instruction exists.
- R2: An instruction with a single fault commits in the cycle it occupies the memory stage with adv_i high. cause_o then takes the value fetch=1, decode=2, execute=3 or memory=4, and epc_o takes the PC the instruction was fetched with. Both values are visible from the following cycle.
- R3: Once an instruction carries a fault, flags raised for it by later stages are ignored, so the earliest-detected cause is the one recorded.
- R4: Only the memory-stage instruction can commit. A fault raised for a younger instruction in the same cycle never reaches cause_o, because that instruction is killed.
- R5: An interrupt (irq_i, level) commits with cause 0 and epc_o equal to the memory-stage PC. It is taken only when a valid instruction is in the memory stage, adv_i is high and no synchronous fault commits that cycle. Otherwise it waits.
- R6: In the commit cycle, kill_f_o, kill_d_o, kill_e_o and wb_suppress_o are all high. kill_d_o, kill_e_o and wb_suppress_o are low in every other cycle.
- R7: In the cycle after a commit (state ST_TRAP), redirect_vld_o is high with redirect_pc_o equal to the TRAP_VEC parameter, and kill_f_o stays high. Both hold until a cycle with adv_i high, and the fetch-stage instruction of those cycles is dropped.
- R8: Killed stages become bubbles with their fault flags cleared. Fault strobes raised while a stage holds a bubble have no effect on cause_o or epc_o.
- R9: With adv_i low, nothing commits and the tracked instructions hold their stage.
- R10: cause_o and epc_o change only on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Pipeline advance enable |
| fetch_vld_i | input | 1 | A real instruction is in fetch |
| fetch_pc_i | input | PC_W | PC of the fetch-stage instruction |
| exc_fetch_i | input | 1 | Fetch address fault for the fetch-stage instruction |
| exc_dec_i | input | 1 | Illegal opcode for the decode-stage instruction |
| exc_exe_i | input | 1 | Arithmetic overflow for the execute-stage instruction |
| exc_mem_i | input | 1 | Data address fault for the memory-stage instruction |
| irq_i | input | 1 | Asynchronous interrupt request, level |
| kill_f_o | output | 1 | Squash the fetch stage |
| kill_d_o | output | 1 | Squash the decode stage |
| kill_e_o | output | 1 | Squash the execute stage |
| wb_suppress_o | output | 1 | Block writeback of the memory-stage instruction |
| redirect_vld_o | output | 1 | Fetch must load redirect_pc_o |
| redirect_pc_o | output | PC_W | Handler vector |
| epc_o | output | PC_W | Exception PC register |
| cause_o | output | 3 | Cause register |

## Verification
Two functions can fall in the same cycle, and the bench provokes both.

The first is a synchronous memory-stage fault arriving while irq_i is high. The bench holds the interrupt line through a faulting instruction's whole trip down the pipe. It judges that cause 4 and that instruction's PC win. The interrupt must then commit later, on the next valid instruction, with cause 0.

The second is an older instruction's commit arriving in the same cycle as faults raised for younger instructions. The bench judges that only the older cause is recorded and that the squashed instructions never trap afterwards. A behavioural stage model compares every output every cycle.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [2:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_FETCH   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4
    } cause_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } trap_st_e;

    // Tracking registers: decode, execute, memory.
    localparam int NUM_TRACK = 3;

    // Detection code of the stage feeding tracking register idx.
    function automatic cause_e feed_code(input int idx);
        cause_e c;
        unique case (idx)
            0:       c = CAUSE_FETCH;
            1:       c = CAUSE_ILLEGAL;
            default: c = CAUSE_OVF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ptc_stage.sv
module ptc_stage
    import ptc_pkg::*;
#(
    parameter int     PC_W = 32,
    parameter cause_e CODE = CAUSE_FETCH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            flush_i,
    input  logic            up_vld_i,
    input  logic            up_exc_i,
    input  cause_e          up_cause_i,
    input  logic [PC_W-1:0] up_pc_i,
    input  logic            det_i,
    output logic            q_vld_o,
    output logic            q_exc_o,
    output cause_e          q_cause_o,
    output logic [PC_W-1:0] q_pc_o
);

    logic   mg_exc;
    cause_e mg_cause;

    // A fault already carried keeps its code; a bubble cannot pick one up.
    always_comb begin
        mg_exc   = up_exc_i | (up_vld_i & det_i);
        mg_cause = up_exc_i ? up_cause_i : CODE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld_o   <= 1'b0;
            q_exc_o   <= 1'b0;
            q_cause_o <= CAUSE_IRQ;
            q_pc_o    <= '0;
        end else if (flush_i) begin
            q_vld_o   <= 1'b0;
            q_exc_o   <= 1'b0;
        end else if (adv_i) begin
            q_vld_o   <= up_vld_i;
            q_exc_o   <= mg_exc;
            q_cause_o <= mg_cause;
            q_pc_o    <= up_pc_i;
        end
    end

endmodule

// File: rtl/ptc_commit.sv
module ptc_commit
    import ptc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] TRAP_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            m_vld_i,
    input  logic            m_exc_i,
    input  cause_e          m_cause_i,
    input  logic [PC_W-1:0] m_pc_i,
    input  logic            exc_mem_i,
    input  logic            irq_i,
    output logic            commit_o,
    output logic            kill_f_o,
    output logic            redirect_vld_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [PC_W-1:0] epc_o,
    output cause_e          cause_o
);

    trap_st_e st_q, st_nxt;
    logic     sync_flt, take_sync, take_irq;
    cause_e   new_cause;

    always_comb begin
        sync_flt  = m_vld_i & (m_exc_i | exc_mem_i);
        take_sync = (st_q == ST_RUN) & adv_i & sync_flt;
        take_irq  = (st_q == ST_RUN) & adv_i & m_vld_i & irq_i & ~sync_flt;
        commit_o  = take_sync | take_irq;
        if (!take_sync)   new_cause = CAUSE_IRQ;
        else if (m_exc_i) new_cause = m_cause_i;
        else              new_cause = CAUSE_DADDR;
        unique case (st_q)
            ST_RUN:  st_nxt = commit_o ? ST_TRAP : ST_RUN;
            ST_TRAP: st_nxt = adv_i ? ST_RUN : ST_TRAP;
            default: st_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= CAUSE_IRQ;
        end else if (commit_o) begin
            epc_o   <= m_pc_i;
            cause_o <= new_cause;
        end
    end

    always_comb begin
        redirect_pc_o = TRAP_VEC;
        unique case (st_q)
            ST_RUN: begin
                kill_f_o       = commit_o;
                redirect_vld_o = 1'b0;
            end
            ST_TRAP: begin
                kill_f_o       = 1'b1;
                redirect_vld_o = 1'b1;
            end
            default: begin
                kill_f_o       = 1'b0;
                redirect_vld_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/precise_trap_ctrl.sv
module precise_trap_ctrl
    import ptc_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] TRAP_VEC = 32'h0000_0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            fetch_vld_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            exc_fetch_i,
    input  logic            exc_dec_i,
    input  logic            exc_exe_i,
    input  logic            exc_mem_i,
    input  logic            irq_i,
    output logic            kill_f_o,
    output logic            kill_d_o,
    output logic            kill_e_o,
    output logic            wb_suppress_o,
    output logic            redirect_vld_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic [PC_W-1:0] epc_o,
    output logic [2:0]      cause_o
);

    localparam int LAST = NUM_TRACK;

    // Index 0 is the fetch input, 1..NUM_TRACK the tracking registers.
    logic [LAST:0]   tr_vld;
    logic [LAST:0]   tr_exc;
    cause_e          tr_cause [LAST+1];
    logic [PC_W-1:0] tr_pc    [LAST+1];
    logic [LAST-1:0] det;
    logic            commit;
    cause_e          cause_q;

    assign det         = {exc_exe_i, exc_dec_i, exc_fetch_i};
    assign tr_vld[0]   = fetch_vld_i & ~kill_f_o;
    assign tr_exc[0]   = 1'b0;
    assign tr_cause[0] = CAUSE_IRQ;
    assign tr_pc[0]    = fetch_pc_i;

    for (genvar i = 0; i < NUM_TRACK; i++) begin : g_track
        ptc_stage #(.PC_W(PC_W), .CODE(feed_code(i))) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (adv_i),
            .flush_i    (commit),
            .up_vld_i   (tr_vld[i]),
            .up_exc_i   (tr_exc[i]),
            .up_cause_i (tr_cause[i]),
            .up_pc_i    (tr_pc[i]),
            .det_i      (det[i]),
            .q_vld_o    (tr_vld[i+1]),
            .q_exc_o    (tr_exc[i+1]),
            .q_cause_o  (tr_cause[i+1]),
            .q_pc_o     (tr_pc[i+1])
        );
    end

    ptc_commit #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_commit (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv_i          (adv_i),
        .m_vld_i        (tr_vld[LAST]),
        .m_exc_i        (tr_exc[LAST]),
        .m_cause_i      (tr_cause[LAST]),
        .m_pc_i         (tr_pc[LAST]),
        .exc_mem_i      (exc_mem_i),
        .irq_i          (irq_i),
        .commit_o       (commit),
        .kill_f_o       (kill_f_o),
        .redirect_vld_o (redirect_vld_o),
        .redirect_pc_o  (redirect_pc_o),
        .epc_o          (epc_o),
        .cause_o        (cause_q)
    );

    assign kill_d_o      = commit;
    assign kill_e_o      = commit;
    assign wb_suppress_o = commit;
    assign cause_o       = cause_q;

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] TRAP_VEC = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            adv_i,
    input logic            exc_mem_i,
    input logic            kill_f_o,
    input logic            kill_d_o,
    input logic            kill_e_o,
    input logic            wb_suppress_o,
    input logic            redirect_vld_o,
    input logic [PC_W-1:0] redirect_pc_o,
    input logic [PC_W-1:0] epc_o,
    input logic [2:0]      cause_o
);

    p_kill_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_suppress_o |-> (kill_f_o && kill_d_o && kill_e_o));

    p_redirect_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_suppress_o |=> redirect_vld_o);

    p_redirect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld_o && !adv_i) |=> redirect_vld_o);

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld_o |-> (redirect_pc_o == TRAP_VEC && kill_f_o));

    p_no_stall_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |-> !wb_suppress_o);

    p_bubble_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld_o |-> !wb_suppress_o);

    p_sync_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_suppress_o && exc_mem_i) |=> (cause_o != 3'd0));

    p_regs_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_suppress_o |=> ($stable(cause_o) && $stable(epc_o)));

endmodule

bind precise_trap_ctrl ptc_checker #(.PC_W(PC_W), .TRAP_VEC(TRAP_VEC)) u_chk (.*);

// File: tb/precise_trap_ctrl_bench.sv
module precise_trap_ctrl_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VEC        = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv, fvld, ef, ed, ee, em, irq;
    logic [31:0] fpc;
    logic        kf, kd, ke, wbs, rdv;
    logic [31:0] rdpc, epc;
    logic [2:0]  cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    precise_trap_ctrl #(.PC_W(32), .TRAP_VEC(VEC)) u_precise_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .fetch_vld_i(fvld),
        .fetch_pc_i(fpc), .exc_fetch_i(ef), .exc_dec_i(ed), .exc_exe_i(ee),
        .exc_mem_i(em), .irq_i(irq), .kill_f_o(kf), .kill_d_o(kd),
        .kill_e_o(ke), .wb_suppress_o(wbs), .redirect_vld_o(rdv),
        .redirect_pc_o(rdpc), .epc_o(epc), .cause_o(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: slot 0 decode, 1 execute, 2 memory.
    bit          mv [3];
    bit          mx [3];
    logic [2:0]  mc [3];
    logic [31:0] mp [3];
    bit          mtrap;
    logic [2:0]  mcause;
    logic [31:0] mepc;

    function automatic bit m_commit();
        return !mtrap && adv && mv[2] && (mx[2] || em || irq);
    endfunction

    function automatic logic [2:0] m_code();
        if (mx[2]) return mc[2];
        if (em)    return 3'd4;
        return 3'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                mv[i] = 0; mx[i] = 0; mc[i] = 0; mp[i] = 0;
            end
            mtrap = 0; mcause = 0; mepc = 0;
        end else if (m_commit()) begin
            mcause = m_code();
            mepc   = mp[2];
            mtrap  = 1;
            for (int i = 0; i < 3; i++) begin
                mv[i] = 0; mx[i] = 0;
            end
        end else begin
            bit was_trap;
            was_trap = mtrap;
            if (mtrap && adv) mtrap = 0;
            if (adv) begin
                mv[2] = mv[1]; mp[2] = mp[1];
                mx[2] = mx[1] || (mv[1] && ee);
                mc[2] = mx[1] ? mc[1] : 3'd3;
                mv[1] = mv[0]; mp[1] = mp[0];
                mx[1] = mx[0] || (mv[0] && ed);
                mc[1] = mx[0] ? mc[0] : 3'd2;
                mv[0] = fvld && !was_trap; mp[0] = fpc;
                mx[0] = fvld && !was_trap && ef;
                mc[0] = 3'd1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic compare_model();
        bit cm;
        cm = m_commit();
        check("R6 kill/suppress", {28'd0, kf, kd, ke, wbs},
              {28'd0, cm || mtrap, cm, cm, cm});
        check("R7 redirect valid", {31'd0, rdv}, {31'd0, mtrap});
        if (mtrap) check("R7 redirect target", rdpc, VEC);
        check("R2 cause register", {29'd0, cause}, {29'd0, mcause});
        check("R2 epc register", epc, mepc);
    endtask

    task automatic step(input logic v, input logic [31:0] pc, input logic f_e,
                        input logic d_e, input logic e_e, input logic m_e,
                        input logic ir, input logic ad);
        @(negedge clk);
        fvld = v; fpc = pc; ef = f_e; ed = d_e; ee = e_e; em = m_e;
        irq = ir; adv = ad;
        #1;
        compare_model();
    endtask

    task automatic expect_regs(input string tag, input logic [2:0] c, input logic [31:0] pc);
        check({tag, " cause"}, {29'd0, cause}, {29'd0, c});
        check({tag, " epc"}, epc, pc);
    endtask

    // Fault flags for one instruction: fetch, then decode, execute, memory.
    task automatic run_case(input logic [31:0] pc, input logic f_e, input logic d_e,
                            input logic e_e, input logic m_e);
        step(1, pc,       f_e, 0,   0,   0,   0, 1);
        step(1, pc + 4,   0,   d_e, 0,   0,   0, 1);
        step(1, pc + 8,   0,   0,   e_e, 0,   0, 1);
        step(1, pc + 12,  0,   0,   0,   m_e, 0, 1);
        step(1, pc + 16,  0,   0,   0,   0,   0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; adv = 0; fvld = 0; fpc = 0; ef = 0; ed = 0; ee = 0;
        em = 0; irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1 outputs after reset", {25'd0, kf, kd, ke, wbs, rdv, cause},
              32'd0);
        check("R1 epc after reset", epc, 32'd0);

        for (int i = 0; i < 4; i++) step(1, 32'h100 + 4 * i, 0, 0, 0, 0, 0, 1);
        expect_regs("R10 clean stream", 3'd0, 32'd0);

        run_case(32'h200, 1, 1, 1, 1);
        expect_regs("R3 fetch fault beats later flags", 3'd1, 32'h200);
        run_case(32'h300, 0, 1, 0, 0);
        expect_regs("R2 illegal opcode", 3'd2, 32'h300);
        run_case(32'h400, 0, 0, 1, 1);
        expect_regs("R3 overflow beats data fault", 3'd3, 32'h400);
        run_case(32'h500, 0, 0, 0, 1);
        expect_regs("R2 data address", 3'd4, 32'h500);
        run_case(32'h600, 0, 0, 1, 0);
        expect_regs("R2 overflow", 3'd3, 32'h600);

        // R4: older commits, younger faulting instruction is squashed
        step(1, 32'h700, 0, 0, 0, 0, 0, 1);
        step(1, 32'h704, 1, 0, 0, 0, 0, 1);
        step(1, 32'h708, 0, 1, 0, 0, 0, 1);
        step(1, 32'h70C, 0, 0, 1, 1, 0, 1);
        step(1, 32'h710, 0, 0, 0, 0, 0, 1);
        expect_regs("R4 older fault recorded", 3'd4, 32'h700);
        // R8: strobes on bubbles have no effect
        for (int i = 0; i < 4; i++) step(0, 32'h0, 1, 1, 1, 1, 0, 1);
        expect_regs("R8 bubbles ignored", 3'd4, 32'h700);

        // R5: fault and interrupt in the same commit cycle
        step(1, 32'h800, 0, 0, 0, 0, 1, 1);
        step(1, 32'h804, 0, 0, 0, 0, 1, 1);
        step(1, 32'h808, 0, 0, 0, 0, 1, 1);
        step(1, 32'h80C, 0, 0, 0, 1, 1, 1);
        step(1, 32'h810, 0, 0, 0, 0, 1, 1);
        expect_regs("R5 sync fault wins over irq", 3'd4, 32'h800);
        step(1, 32'h900, 0, 0, 0, 0, 1, 1);
        step(1, 32'h904, 0, 0, 0, 0, 1, 1);
        step(1, 32'h908, 0, 0, 0, 0, 1, 1);
        step(1, 32'h90C, 0, 0, 0, 0, 1, 1);
        step(1, 32'h910, 0, 0, 0, 0, 0, 1);
        expect_regs("R5 irq taken later", 3'd0, 32'h900);

        // R9: stall holds the faulting instruction at the commit point
        step(1, 32'hA00, 0, 0, 0, 0, 0, 1);
        step(1, 32'hA04, 0, 0, 0, 0, 0, 1);
        step(1, 32'hA08, 0, 0, 0, 0, 0, 1);
        step(1, 32'hA0C, 0, 0, 0, 1, 0, 0);
        step(1, 32'hA0C, 0, 0, 0, 1, 0, 0);
        expect_regs("R9 no commit while stalled", 3'd0, 32'h900);
        step(1, 32'hA0C, 0, 0, 0, 1, 0, 1);
        // R7: redirect held across stalled cycles
        step(1, 32'hA10, 0, 0, 0, 0, 0, 0);
        step(1, 32'hA10, 0, 0, 0, 0, 0, 0);
        step(1, 32'hA10, 0, 0, 0, 0, 0, 1);
        expect_regs("R9 commit after stall", 3'd4, 32'hA00);

        for (int i = 0; i < 5; i++) step(1, 32'hB00 + 4 * i, 0, 0, 0, 0, 0, 1);
        expect_regs("R10 registers hold", 3'd4, 32'hA00);
        step(0, 32'h0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule